// File: doc/BRIEF.md
# Serial Memory Bus Addressing Receiver

This block is the slave-side front end of a two-wire serial memory holding 8192 bytes. It brings the clock and data lines into the system clock domain and finds bus Start and Stop conditions. It shifts in the first byte of each transfer and compares its device-type nibble and three chip-select bits with the block's own identity. If the byte matches, the block acknowledges by enabling its open-drain data driver. If it does not match, the block stays silent until the next Start.

For a write, the block takes two more bytes as the word address, high byte first. It drops the unused upper bits and loads the 13-bit result into a pointer that a memory controller reads. The controller advances the pointer with an increment strobe. The pointer wraps within this device's 8K space, so sequential access never crosses into another device. A parameter selects a variant with no strap pins, in which the chip-select bits must be zero.

Top module: `eeprom_addr_rx`

## Requirements
- R1: A Start (data falls while clock is high) or a Stop (data rises while clock is high) clears the bit and byte counters at any point. Both release the data driver. A Stop deselects the device. A repeated Start in the middle of a byte restarts reception at the control byte.
- R2: Data bits are taken on each clock rising edge, most significant bit first.
- R3: A control byte whose bits 7:4 are 1010 and whose bits 3:1 equal strap_i[2:0] asserts sel_o and sda_oe_o. sda_oe_o goes high on the clock falling edge after the eighth bit and goes low on the falling edge that ends the ninth clock. The same acknowledge applies to each write address byte.
- R4: A control byte with a wrong device code or wrong chip bits gets no acknowledge. The block then ignores all further bytes until the next Start, and ptr_o does not change.
- R5: Control bit 0 selects the operation, with 1 meaning read and 0 meaning write. op_rd_o shows this bit while the device is selected. A read does not load the pointer from any later byte.
- R6: After a write control byte, the next two bytes are the word address, high byte first. ptr_o becomes {high[4:0], low[7:0]}, so high[7:5] is ignored. addr_load_o pulses for one cycle in the cycle ptr_o takes the new value.
- R7: A one-cycle ptr_inc_i pulse adds one to ptr_o, and 0x1FFF wraps to 0x0000.
- R8: If an address load and ptr_inc_i fall in the same cycle, the load wins and ptr_o takes the loaded value.
- R9: With USE_STRAPS=0, strap_i is not used and the chip-select bits must be 000 to match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| strap_i | input | 3 | Chip-select strap levels |
| ptr_inc_i | input | 1 | Advance the word pointer by one |
| sda_oe_o | output | 1 | Pull the data line low (acknowledge) |
| sel_o | output | 1 | Device addressed in the current transfer |
| op_rd_o | output | 1 | Operation bit of the accepted control byte |
| addr_load_o | output | 1 | One-cycle strobe when a new word address is loaded |
| ptr_o | output | 13 | Word address pointer |

## Verification
The pointer can be loaded from the low address byte and be incremented by the controller in the same clock cycle. The bench provokes this by holding ptr_inc_i high across the whole acknowledge of the low address byte, which puts an increment in the load cycle. It then compares ptr_o with the decoded address at the addr_load_o strobe and expects the increments to resume only after that strobe. A behavioural bus model predicts every output on every cycle. Directed checks cover mismatched codes, the no-strap variant, reads, wrap-around and a repeated Start in the middle of a byte.

// File: rtl/eeprom_rx_pkg.sv
package eeprom_rx_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;
  localparam int unsigned CHIP_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CTRL, ST_AHI, ST_ALO, ST_WDATA, ST_READ
  } rx_state_e;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  for (genvar g = 0; g < W; g++) begin : g_line
    logic s1_q, s2_q, s3_q;
    // idle bus is high
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
        s3_q <= 1'b1;
      end else begin
        s1_q <= in_i[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign lvl_o[g]  = s2_q;
    assign rise_o[g] = s2_q & ~s3_q;
    assign fall_o[g] = ~s2_q & s3_q;
  end
endmodule

// File: rtl/ctrl_fsm.sv
module ctrl_fsm
  import eeprom_rx_pkg::*;
#(
  parameter int unsigned AW = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  input  logic [CHIP_W-1:0] chip_i,
  output logic              sda_oe_o,
  output logic              sel_o,
  output logic              rd_o,
  output logic              load_o,
  output logic [AW-1:0]     load_addr_o
);
  localparam int unsigned HI_W = AW - 8;

  rx_state_e       state_q;
  logic [3:0]      cnt_q;
  logic [7:0]      sh_q;
  logic [HI_W-1:0] hi_q;
  logic            ack_q;
  logic            in_byte;
  logic            match;

  assign in_byte = (state_q == ST_CTRL) || (state_q == ST_AHI) || (state_q == ST_ALO);
  assign match   = (sh_q[7:4] == DEV_CODE) && (sh_q[3:1] == chip_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      sh_q        <= '0;
      hi_q        <= '0;
      ack_q       <= 1'b0;
      sda_oe_o    <= 1'b0;
      sel_o       <= 1'b0;
      rd_o        <= 1'b0;
      load_o      <= 1'b0;
      load_addr_o <= '0;
    end else if (start_i || stop_i) begin
      state_q  <= start_i ? ST_CTRL : ST_IDLE;
      cnt_q    <= '0;
      ack_q    <= 1'b0;
      sda_oe_o <= 1'b0;
      sel_o    <= 1'b0;
      rd_o     <= 1'b0;
      load_o   <= 1'b0;
    end else begin
      load_o <= 1'b0;
      if (ack_q) begin
        if (scl_fall_i) begin
          ack_q    <= 1'b0;
          sda_oe_o <= 1'b0;
          cnt_q    <= '0;
        end
      end else if (in_byte) begin
        if (scl_rise_i && cnt_q < 4'd8) begin
          sh_q  <= {sh_q[6:0], sda_i};
          cnt_q <= cnt_q + 4'd1;
        end else if (scl_fall_i && cnt_q == 4'd8) begin
          cnt_q <= '0;
          unique case (state_q)
            ST_CTRL: begin
              if (match) begin
                sel_o    <= 1'b1;
                rd_o     <= sh_q[0];
                ack_q    <= 1'b1;
                sda_oe_o <= 1'b1;
                state_q  <= sh_q[0] ? ST_READ : ST_AHI;
              end else begin
                state_q <= ST_IDLE;
              end
            end
            ST_AHI: begin
              hi_q     <= sh_q[HI_W-1:0];
              ack_q    <= 1'b1;
              sda_oe_o <= 1'b1;
              state_q  <= ST_ALO;
            end
            default: begin
              load_o      <= 1'b1;
              load_addr_o <= {hi_q, sh_q};
              ack_q       <= 1'b1;
              sda_oe_o    <= 1'b1;
              state_q     <= ST_WDATA;
            end
          endcase
        end
      end
    end
  end

  AST_OE_NEEDS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> sel_o); // R3
  AST_OE_ONE_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o && scl_fall_i) |=> !sda_oe_o); // R3
  AST_START_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!sda_oe_o && state_q == ST_CTRL)); // R1
  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!sel_o && state_q == ST_IDLE)); // R1
  AST_LOAD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o); // R6
  AST_RD_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o && rd_o) |-> !load_o); // R5
endmodule

// File: rtl/addr_ptr.sv
module addr_ptr #(
  parameter int unsigned AW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic          inc_i,
  output logic [AW-1:0] ptr_o,
  output logic          loaded_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o    <= '0;
      loaded_o <= 1'b0;
    end else begin
      loaded_o <= load_i;
      if (load_i)     ptr_o <= addr_i;
      else if (inc_i) ptr_o <= ptr_o + 1'b1; // wraps inside the device
    end
  end

  AST_PTR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && inc_i && ptr_o == '1) |=> (ptr_o == '0)); // R7
  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (ptr_o == $past(addr_i))); // R8
endmodule

// File: rtl/eeprom_addr_rx.sv
module eeprom_addr_rx
  import eeprom_rx_pkg::*;
#(
  parameter int unsigned AW         = 13,
  parameter bit          USE_STRAPS = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [2:0]    strap_i,
  input  logic          ptr_inc_i,
  output logic          sda_oe_o,
  output logic          sel_o,
  output logic          op_rd_o,
  output logic          addr_load_o,
  output logic [AW-1:0] ptr_o
);
  logic [1:0]        lvl, rise, fall;
  logic              start, stop;
  logic [CHIP_W-1:0] chip;
  logic              load;
  logic [AW-1:0]     load_addr;

  line_sync #(.W(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   ({sda_i, scl_i}),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign start = fall[1] & lvl[0] & ~rise[0];
  assign stop  = rise[1] & lvl[0] & ~rise[0];

  if (USE_STRAPS) begin : g_strap
    assign chip = strap_i;
  end else begin : g_nostrap
    assign chip = '0;
  end

  ctrl_fsm #(.AW(AW)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_rise_i  (rise[0]),
    .scl_fall_i  (fall[0]),
    .start_i     (start),
    .stop_i      (stop),
    .sda_i       (lvl[1]),
    .chip_i      (chip),
    .sda_oe_o    (sda_oe_o),
    .sel_o       (sel_o),
    .rd_o        (op_rd_o),
    .load_o      (load),
    .load_addr_o (load_addr)
  );

  addr_ptr #(.AW(AW)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .addr_i   (load_addr),
    .inc_i    (ptr_inc_i),
    .ptr_o    (ptr_o),
    .loaded_o (addr_load_o)
  );

  AST_NO_START_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start && stop)); // R1
endmodule

// File: tb/eeprom_addr_rx_tb_top.sv
module eeprom_addr_rx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, inc = 1'b0;
  logic [2:0] strap = 3'b101;
  logic oe, sel, rd, ld;
  logic [12:0] ptr;
  logic oe2, sel2, rd2, ld2;
  logic [12:0] ptr2;
  logic line;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  assign line = sda_m & ~oe & ~oe2;

  eeprom_addr_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(line), .strap_i(strap),
    .ptr_inc_i(inc), .sda_oe_o(oe), .sel_o(sel), .op_rd_o(rd),
    .addr_load_o(ld), .ptr_o(ptr));

  eeprom_addr_rx #(.USE_STRAPS(1'b0)) dut_np_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(line), .strap_i(strap),
    .ptr_inc_i(1'b0), .sda_oe_o(oe2), .sel_o(sel2), .op_rd_o(rd2),
    .addr_load_o(ld2), .ptr_o(ptr2));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural bus model for dut_i
  int m_st = 0, m_cnt = 0, m_sh = 0, m_hi = 0, m_laddr = 0, m_ptr = 0;
  bit m_ack = 0, m_oe = 0, m_sel = 0, m_rd = 0, m_load = 0, m_ld_out = 0;
  bit s_scl = 1, s_sda = 1, s_inc = 0;
  bit h1c = 1, h2c = 1, h3c = 1, h1d = 1, h2d = 1, h3d = 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_sh = 0; m_hi = 0; m_laddr = 0; m_ptr = 0;
      m_ack = 0; m_oe = 0; m_sel = 0; m_rd = 0; m_load = 0; m_ld_out = 0;
      h1c = 1; h2c = 1; h3c = 1; h1d = 1; h2d = 1; h3d = 1;
    end else begin
      bit rise, fall, st, sp;
      rise = h2c && !h3c;
      fall = !h2c && h3c;
      st = h3d && !h2d && h2c && !rise;
      sp = !h3d && h2d && h2c && !rise;
      // pointer stage sees last cycle's load strobe
      m_ld_out = m_load;
      if (m_load) m_ptr = m_laddr;
      else if (s_inc) m_ptr = (m_ptr + 1) % 8192;
      if (st || sp) begin
        m_st = st ? 1 : 0; m_cnt = 0; m_ack = 0; m_oe = 0;
        m_sel = 0; m_rd = 0; m_load = 0;
      end else begin
        m_load = 0;
        if (m_ack) begin
          if (fall) begin m_ack = 0; m_oe = 0; m_cnt = 0; end
        end else if (m_st >= 1 && m_st <= 3) begin
          if (rise && m_cnt < 8) begin
            m_sh = ((m_sh << 1) | int'(h2d)) & 255;
            m_cnt++;
          end else if (fall && m_cnt == 8) begin
            m_cnt = 0;
            if (m_st == 1) begin
              if ((m_sh >> 4) == 10 && ((m_sh >> 1) & 7) == int'(strap)) begin
                m_sel = 1; m_rd = m_sh[0]; m_ack = 1; m_oe = 1;
                m_st = m_rd ? 5 : 2;
              end else m_st = 0;
            end else if (m_st == 2) begin
              m_hi = m_sh & 31; m_ack = 1; m_oe = 1; m_st = 3;
            end else begin
              m_load = 1; m_laddr = (m_hi << 8) | m_sh; m_ack = 1; m_oe = 1; m_st = 4;
            end
          end
        end
      end
      h3c = h2c; h2c = h1c; h1c = s_scl;
      h3d = h2d; h2d = h1d; h1d = s_sda;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk("R3 oe", int'(oe), int'(m_oe));
      chk("R3 sel", int'(sel), int'(m_sel));
      chk("R5 rd", int'(rd), int'(m_rd));
      chk("R6 load", int'(ld), int'(m_ld_out));
      chk("R6 ptr", int'(ptr), m_ptr);
    end
    #5;
    s_scl = scl_m; s_sda = line; s_inc = inc;
  end

  task automatic step(bit c, bit d);
    @(negedge clk); #2;
    scl_m = c; sda_m = d;
    repeat (6) @(posedge clk);
  endtask
  task automatic put_bit(bit b);
    step(0, sda_m);
    step(0, b);
    step(1, b);
  endtask
  task automatic put_byte(logic [7:0] v);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    step(0, sda_m);
    step(0, 1'b1);
    step(1, 1'b1);
    step(0, 1'b1);
  endtask
  task automatic do_start();
    step(0, 1'b1); step(1, 1'b1); step(1, 1'b0); step(0, 1'b0);
  endtask
  task automatic do_stop();
    step(0, 1'b0); step(1, 1'b0); step(1, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset oe", int'(oe), 0);
    chk("R1 reset sel", int'(sel), 0);
    chk("R1 reset ptr", int'(ptr), 0);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // write address, top bits of high byte set
    do_start();
    put_byte(8'hAA);
    chk("R3 sel after ctrl", int'(sel), 1);
    put_byte(8'hFA);
    put_byte(8'hBC);
    chk("R2 R6 ptr", int'(ptr), 'h1ABC);
    do_stop();
    repeat (4) @(posedge clk);
    chk("R1 stop deselects", int'(sel), 0);

    // chip bits 000: dut_i mismatch, no-strap variant matches
    do_start();
    put_byte(8'hA0);
    chk("R4 no sel on chip mismatch", int'(sel), 0);
    chk("R9 no-strap variant selects 000", int'(sel2), 1);
    put_byte(8'h00);
    put_byte(8'h11);
    chk("R4 ptr untouched", int'(ptr), 'h1ABC);
    chk("R9 no-strap variant ptr", int'(ptr2), 'h0011);
    do_stop();

    // wrong device code
    do_start();
    put_byte(8'hBA);
    chk("R4 wrong code", int'(sel), 0);
    chk("R9 variant ignores 101", int'(sel2), 0);
    do_stop();

    // read
    do_start();
    put_byte(8'hAB);
    chk("R5 rd", int'(rd), 1);
    chk("R5 sel", int'(sel), 1);
    put_byte(8'h55);
    put_byte(8'h66);
    chk("R5 read no load", int'(ptr), 'h1ABC);
    do_stop();

    // wrap
    do_start();
    put_byte(8'hAA); put_byte(8'hFF); put_byte(8'hFF);
    chk("R6 ptr max", int'(ptr), 'h1FFF);
    @(negedge clk); #2 inc = 1'b1;
    @(negedge clk); #2 inc = 1'b0;
    @(negedge clk);
    chk("R7 wrap", int'(ptr), 0);
    do_stop();

    // load and increment in the same cycle
    do_start();
    put_byte(8'hAA); put_byte(8'h02);
    @(negedge clk); #2 inc = 1'b1;
    fork
      put_byte(8'h34);
      begin
        int n = 0;
        @(negedge clk);
        while (!ld && n < 2000) begin @(negedge clk); n++; end
        chk("R8 load wins", int'(ptr), 'h0234);
        #2 inc = 1'b0;
      end
    join
    do_stop();

    // repeated start inside a byte
    do_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    do_start();
    put_byte(8'hAA);
    chk("R1 restart mid-byte", int'(sel), 1);
    put_byte(8'h07); put_byte(8'h21);
    chk("R1 R2 ptr after restart", int'(ptr), 'h0721);
    do_stop();
    repeat (10) @(posedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule